// File: doc/BRIEF.md
# Two-Wire Register Slave with Soft Device Address

This block is a slave on a two-wire serial bus (clock and open-drain data). A host on the bus uses it to reach a small register file inside the chip. Both bus lines are oversampled by the system clock. Start and stop conditions are found by watching the data line while the clock line is high. The first byte of each transaction carries a 7-bit device address and a direction bit.

The device address has two parts. The lower two bits come from strap pins, captured once during reset. The upper five bits are soft: they come out of reset at a default value, and the host can change them by writing a reserved register index. A write transaction loads an internal pointer from its first data byte and may write its second byte to the register that the pointer names. A read transaction returns one byte from that register.

Toward the rest of the chip the block offers a plain register port: an address, a one-cycle write enable with its data, and a combinational read-data input. The data line is driven only as an open-drain pull-down enable.

Top module: `sbusRegSlave`

## Requirements
- R1: A START is the data line falling while the clock line is high. A STOP is the data line rising while the clock line is high. After a STOP the block acknowledges nothing until the next START.
- R2: After a START the block shifts in eight bits, MSB first: the 7-bit device address followed by the direction bit (0 = write, 1 = read). On an address match it pulls SDA low (`sdaOe` = 1) for the ninth clock.
- R3: After reset the device address is binary 01011 followed by the values of `strapA1` and `strapA0` captured during reset. Out of reset, `sdaOe`, `regWrEn` and `regAddr` are all 0.
- R4: When the address does not match, the block does not acknowledge. It does not write, it leaves the pointer unchanged, and it ignores the bus until the next START.
- R5: In a write transaction, the first byte after the address is loaded into the pointer, which appears on `regAddr`.
- R6: The second byte of a write transaction produces a one-cycle `regWrEn` pulse, with `regWrData` equal to that byte and `regAddr` equal to the pointer.
- R7: Every data byte of a write transaction is acknowledged. Bytes after the second cause no write.
- R8: A read transaction returns one byte from the register the pointer selects, MSB first. After the eighth bit the block releases SDA and stays released until a START.
- R9: Writing to index `SELF_IDX` (default 0x2F) copies bits 6..2 of the data byte into the soft address bits and raises no `regWrEn`. The strap bits do not change. Later transactions must use the new address, and the old address is no longer acknowledged. Reading index `SELF_IDX` returns {0, current 7-bit address}.
- R10: A START during any transfer, including partway through a byte, aborts that transfer and restarts address reception. This makes a repeated START between a pointer write and a read work.
- R11: `sdaOe` changes only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low reset; straps are captured while it is low |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level |
| strapA1 | input | 1 | Strap for device address bit 1 |
| strapA0 | input | 1 | Strap for device address bit 0 |
| sdaOe | output | 1 | 1 pulls the data line low |
| regAddr | output | 8 | Register index (the pointer) |
| regWrEn | output | 1 | One-cycle register write strobe |
| regWrData | output | 8 | Register write data |
| regRdData | input | 8 | Read data of the register at `regAddr` |

## Verification
The assertions assume that each clock-line low phase lasts longer than the synchronizer delay. They also assume the host moves the data line only while the clock is low, except when it forms a START or a STOP. Under those assumptions the block's own data-line changes fall inside the low phase, and every pointer load or write is followed by an acknowledge. The bench's bus master holds each half-bit for ten system clocks. It changes the data line two clocks after the clock line falls, or at the start of a low phase, and it never releases the data line during the clock-high phase except to form a STOP or START.

// File: rtl/sbusPkg.sv
package sbusPkg;
  localparam int DATA_W     = 8;
  localparam int DEV_ADDR_W = 7;
  localparam int STRAP_W    = 2;
  localparam int SOFT_W     = DEV_ADDR_W - STRAP_W;
  localparam int CNT_W      = $clog2(DATA_W);

  typedef struct packed {
    logic shiftIn;    // capture the sampled data bit
    logic shiftOut;   // advance the read shifter
    logic loadRd;     // load read byte into the shifter
    logic loadPtr;    // shifter -> pointer
    logic writeReg;   // shifter -> selected register
    logic driveAck;   // pull SDA for acknowledge
    logic driveData;  // present shifter MSB on SDA
  } ctrlStrobes_t;
endpackage

// File: rtl/sbusCtrl.sv
module sbusCtrl
  import sbusPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         sclIn,
  input  logic         sdaIn,
  input  logic         addrMatch,
  input  logic         rwBit,
  output ctrlStrobes_t strb,
  output logic         sdaBit
);
  typedef enum logic [2:0] {
    IDLE, ADDR, ADDR_END, ACK, WDATA, WD_END, RDATA, WAITSTOP
  } state_t;

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic sclMeta, sclSync, sclPrev;
  logic sdaMeta, sdaSync, sdaPrev;
  logic sclRise, sclFall, startEv, stopEv;
  state_t state;
  logic [CNT_W-1:0] bitCnt;
  logic [1:0] byteIdx;
  logic isRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {sclMeta, sclSync, sclPrev} <= 3'b111;
      {sdaMeta, sdaSync, sdaPrev} <= 3'b111;
    end else begin
      sclMeta <= sclIn;  sclSync <= sclMeta; sclPrev <= sclSync;
      sdaMeta <= sdaIn;  sdaSync <= sdaMeta; sdaPrev <= sdaSync;
    end
  end

  assign sclRise = sclSync & ~sclPrev;
  assign sclFall = ~sclSync & sclPrev;
  assign startEv = sclSync & sclPrev & sdaPrev & ~sdaSync;
  assign stopEv  = sclSync & sclPrev & ~sdaPrev & sdaSync;
  assign sdaBit  = sdaSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= IDLE;
      bitCnt  <= '0;
      byteIdx <= '0;
      isRead  <= 1'b0;
    end else if (startEv) begin
      state   <= ADDR;
      bitCnt  <= '0;
      byteIdx <= '0;
    end else if (stopEv) begin
      state <= IDLE;
    end else begin
      unique case (state)
        ADDR: if (sclRise) begin
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == LAST_BIT) state <= ADDR_END;
        end
        ADDR_END: if (sclFall) begin
          if (addrMatch) begin
            state  <= ACK;
            isRead <= rwBit;
          end else begin
            state <= IDLE;
          end
        end
        ACK: if (sclFall) begin
          bitCnt <= '0;
          state  <= isRead ? RDATA : WDATA;
        end
        WDATA: if (sclRise) begin
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == LAST_BIT) state <= WD_END;
        end
        WD_END: if (sclFall) begin
          state <= ACK;
          if (byteIdx != 2'd2) byteIdx <= byteIdx + 1'b1;
        end
        RDATA: if (sclFall) begin
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == LAST_BIT) state <= WAITSTOP;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strb           = '0;
    strb.shiftIn   = sclRise & ~startEv & ~stopEv & (state == ADDR || state == WDATA);
    strb.loadRd    = sclFall & (state == ACK) & isRead;
    strb.shiftOut  = sclFall & (state == RDATA) & (bitCnt != LAST_BIT);
    strb.loadPtr   = sclFall & (state == WD_END) & (byteIdx == 2'd0);
    strb.writeReg  = sclFall & (state == WD_END) & (byteIdx == 2'd1);
    strb.driveAck  = (state == ACK);
    strb.driveData = (state == RDATA);
  end
endmodule

// File: rtl/sbusDatapath.sv
module sbusDatapath
  import sbusPkg::*;
#(
  parameter logic [SOFT_W-1:0] SOFT_RST = 5'b01011,
  parameter logic [DATA_W-1:0] SELF_IDX = 8'h2F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapA1,
  input  logic              strapA0,
  input  ctrlStrobes_t      strb,
  input  logic              sdaBit,
  input  logic [DATA_W-1:0] regRdData,
  output logic              addrMatch,
  output logic              rwBit,
  output logic              sdaOe,
  output logic [DATA_W-1:0] regAddr,
  output logic              regWrEn,
  output logic [DATA_W-1:0] regWrData
);
  logic [SOFT_W-1:0]     softAddr;
  logic [STRAP_W-1:0]    strapReg;
  logic [DEV_ADDR_W-1:0] devAddr;
  logic [DATA_W-1:0]     shReg, ptr;
  logic                  selfSel;

  assign devAddr = {softAddr, strapReg};
  assign selfSel = (ptr == SELF_IDX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      softAddr <= SOFT_RST;
      strapReg <= {strapA1, strapA0};
      shReg    <= '0;
      ptr      <= '0;
    end else begin
      if (strb.shiftIn)       shReg <= {shReg[DATA_W-2:0], sdaBit};
      else if (strb.shiftOut) shReg <= {shReg[DATA_W-2:0], 1'b0};
      else if (strb.loadRd)   shReg <= selfSel ? DATA_W'(devAddr) : regRdData;
      if (strb.loadPtr) ptr <= shReg;
      if (strb.writeReg && selfSel) softAddr <= shReg[DEV_ADDR_W-1:STRAP_W];
    end
  end

  assign addrMatch = (shReg[DATA_W-1:1] == devAddr);
  assign rwBit     = shReg[0];
  assign sdaOe     = strb.driveAck | (strb.driveData & ~shReg[DATA_W-1]);
  assign regAddr   = ptr;
  assign regWrEn   = strb.writeReg & ~selfSel;
  assign regWrData = shReg;
endmodule

// File: rtl/sbusRegSlave.sv
module sbusRegSlave
  import sbusPkg::*;
#(
  parameter logic [SOFT_W-1:0] SOFT_RST = 5'b01011,
  parameter logic [DATA_W-1:0] SELF_IDX = 8'h2F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              strapA1,
  input  logic              strapA0,
  output logic              sdaOe,
  output logic [DATA_W-1:0] regAddr,
  output logic              regWrEn,
  output logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] regRdData
);
  ctrlStrobes_t strb;
  logic addrMatch, rwBit, sdaBit;

  sbusCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .addrMatch(addrMatch), .rwBit(rwBit), .strb(strb), .sdaBit(sdaBit)
  );

  sbusDatapath #(.SOFT_RST(SOFT_RST), .SELF_IDX(SELF_IDX)) dp_i (
    .clk(clk), .rstN(rstN), .strapA1(strapA1), .strapA0(strapA0),
    .strb(strb), .sdaBit(sdaBit), .regRdData(regRdData),
    .addrMatch(addrMatch), .rwBit(rwBit), .sdaOe(sdaOe),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData)
  );
endmodule

// File: rtl/sbusRegSlaveChk.sv
module sbusRegSlaveChk (
  input logic       clk,
  input logic       rstN,
  input logic       sclIn,
  input logic       sdaOe,
  input logic [7:0] regAddr,
  input logic       regWrEn
);
  // R11: own data-line changes happen only in the clock-low phase
  assert_sda_scl_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe != $past(sdaOe)) |-> !sclIn);

  // R6: write strobe lasts exactly one cycle
  assert_wr_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  // R7: an accepted write byte is acknowledged
  assert_wr_acked_R7: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> sdaOe);

  // R5: a pointer update coincides with the acknowledge of its byte
  assert_ptr_acked_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr != $past(regAddr)) |-> sdaOe);
endmodule

bind sbusRegSlave sbusRegSlaveChk chk_i (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe),
  .regAddr(regAddr), .regWrEn(regWrEn)
);

// File: tb/sbusRegSlave_tb.sv
module sbusRegSlave_tb_top;
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1, sdaDrv = 1'b1;
  logic sdaOe, regWrEn;
  logic [7:0] regAddr, regWrData, regRdData;
  logic sdaLine;
  logic [7:0] mem [256];
  int wrCount = 0;
  int testsRun = 0, failures = 0;

  always #2 clk = ~clk;

  assign sdaLine   = sdaDrv & ~sdaOe;
  assign regRdData = mem[regAddr];

  sbusRegSlave dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine),
    .strapA1(1'b1), .strapA0(1'b0), .sdaOe(sdaOe),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData)
  );

  initial for (int i = 0; i < 256; i++) mem[i] = 8'h00;

  always @(posedge clk) if (regWrEn) begin
    mem[regAddr] <= regWrData;
    wrCount <= wrCount + 1;
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic halfWait; repeat (HALF) @(negedge clk); endtask

  task automatic busStart;
    sdaDrv = 1'b1; halfWait; sclDrv = 1'b1; halfWait;
    sdaDrv = 1'b0; halfWait; sclDrv = 1'b0; repeat (2) @(negedge clk);
  endtask

  task automatic busStop;
    sdaDrv = 1'b0; halfWait; sclDrv = 1'b1; halfWait;
    sdaDrv = 1'b1; halfWait;
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaDrv = b[i]; halfWait; sclDrv = 1'b1; halfWait;
      sclDrv = 1'b0; repeat (2) @(negedge clk);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ackd);
    sendBits(b, 8);
    sdaDrv = 1'b1; halfWait; sclDrv = 1'b1; halfWait;
    ackd = ~sdaLine;
    sclDrv = 1'b0; repeat (2) @(negedge clk);
  endtask

  task automatic readByte(output logic [7:0] d);
    sdaDrv = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      halfWait; sclDrv = 1'b1; halfWait;
      d[i] = sdaLine;
      sclDrv = 1'b0; repeat (2) @(negedge clk);
    end
    sdaDrv = 1'b1; halfWait; sclDrv = 1'b1; halfWait;  // NACK
    sclDrv = 1'b0; repeat (2) @(negedge clk);
  endtask

  task automatic testReset;
    check("R3 sdaOe after reset", sdaOe, 0);
    check("R3 regWrEn after reset", regWrEn, 0);
    check("R3 regAddr after reset", regAddr, 0);
  endtask

  task automatic testWrite;
    logic a0, a1, a2;
    int c0 = wrCount;
    busStart; sendByte(8'h5C, a0); sendByte(8'h05, a1); sendByte(8'hA7, a2); busStop;
    check("R2 R3 address ack strap 10", a0, 1);
    check("R5 pointer byte ack", a1, 1);
    check("R5 regAddr holds pointer", regAddr, 8'h05);
    check("R6 one write", wrCount - c0, 1);
    check("R6 written data", mem[5], 8'hA7);
  endtask

  task automatic testRead;
    logic a0, a1, a2; logic [7:0] d;
    busStart; sendByte(8'h5C, a0); sendByte(8'h05, a1); busStop;
    busStart; sendByte(8'h5D, a2); readByte(d);
    check("R8 read ack", a2, 1);
    check("R8 read data", d, 8'hA7);
    check("R8 released after byte", sdaOe, 0);
    busStop;
  endtask

  task automatic testWrongAddr;
    logic a0, a1;
    int c0 = wrCount;
    busStart; sendByte(8'h5A, a0); sendByte(8'h09, a1); busStop;
    check("R4 no ack wrong strap", a0, 0);
    check("R4 no ack following byte", a1, 0);
    check("R4 pointer unchanged", regAddr, 8'h05);
    check("R4 no write", wrCount - c0, 0);
  endtask

  task automatic testExtraBytes;
    logic a0, a1, a2, a3, a4;
    int c0 = wrCount;
    busStart; sendByte(8'h5C, a0); sendByte(8'h07, a1);
    sendByte(8'h11, a2); sendByte(8'h22, a3); sendByte(8'h33, a4); busStop;
    check("R7 extra bytes acked", {a2, a3, a4}, 3'b111);
    check("R7 single write", wrCount - c0, 1);
    check("R7 target keeps second byte", mem[7], 8'h11);
  endtask

  task automatic testRepeatedStart;
    logic a0, a1, a2; logic [7:0] d;
    busStart; sendByte(8'h5C, a0); sendByte(8'h05, a1);
    busStart; sendByte(8'h5D, a2); readByte(d); busStop;
    check("R10 repeated start read", d, 8'hA7);
  endtask

  task automatic testAbort;
    logic a0, a1, a2;
    busStart; sendBits(8'h5C, 4);
    busStart; sendByte(8'h5C, a0); sendByte(8'h09, a1); sendByte(8'h3C, a2); busStop;
    check("R10 abort then ack", a0, 1);
    check("R10 write after abort", mem[9], 8'h3C);
  endtask

  task automatic testAddrChange;
    logic a0, a1, a2, a3, a4; logic [7:0] d;
    int c0 = wrCount;
    busStart; sendByte(8'h5C, a0); sendByte(8'h2F, a1); sendByte(8'h49, a2); busStop;
    check("R9 no regWrEn for self register", wrCount - c0, 0);
    busStart; sendByte(8'h5C, a3); busStop;
    check("R9 old address not acked", a3, 0);
    busStart; sendByte(8'h95, a4); readByte(d); busStop;
    check("R9 new address acked", a4, 1);
    check("R9 self register readback", d, 8'h4A);
  endtask

  task automatic testNoStart;
    logic a0;
    sendByte(8'h94, a0);
    check("R1 no ack without START", a0, 0);
    busStop;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    testReset;
    testWrite;
    testRead;
    testWrongAddr;
    testExtraBytes;
    testRepeatedStart;
    testAbort;
    testAddrChange;
    testNoStart;
    $display("[TB] %0d tests run, %0d failed", testsRun, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    testsRun++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", testsRun, failures);
    $finish;
  end
endmodule